// File: doc/BRIEF.md
# Indexed configuration and I/O port bridge

This block gives a big-endian processor a register-mapped, indirect route into PCI configuration space and PCI I/O space. Software first loads a shared index register with a target address. It then reads or writes one of two four-byte data windows. Each accepted window access becomes exactly one downstream request, which carries an address, a size, a direction and, for writes, the data in the byte order that window uses.

The two windows treat the index differently. The configuration window ORs the access's low two offset bits into the index and reverses bytes within the access size. The I/O window adds the offset bits to the index, keeps only 16 address bits and passes the data value through unchanged. Accesses that do not fit the offset, and offsets outside the map, get an error response and cause no downstream traffic. The block handles one access at a time. It holds the processor-side response until the downstream side answers.

Processor offsets are 12 bits wide. Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes; code 3 is never valid. Data is right-justified on both sides.

Top module: `idx_cfg_io_bridge`

## Requirements
- R1: After reset, no response or downstream request is pending, `req_ready` is 1, and the index reads back as zero.
- R2: A four-byte write to offset 0x064 stores the written value with bits [1:0] cleared. A four-byte read there returns the stored index. Both get a response with no error one cycle after acceptance.
- R3: A one-byte or two-byte access to offset 0x064 is answered with an error and leaves the index unchanged.
- R4: An access to offsets 0x068 to 0x06B issues a downstream request with `dn_space`=0, the address equal to the index ORed with the offset's low two bits, and the access's direction and size code.
- R5: On the configuration window, byte order is reversed within the access size. Write data is reversed before it is sent, and read data is reversed before it is returned. Bytes above the access size are zero.
- R6: An access to offsets 0x06C to 0x06F issues a downstream request with `dn_space`=1 and the address equal to bits [15:0] of the index plus the offset's low two bits, zero-extended.
- R7: On the I/O window, data passes unreversed in both directions, masked to the access size.
- R8: Within a window, offset bits 00 accept sizes 1, 2 and 4. Offset bits 10 accept sizes 1 and 2. Offset bits 01 and 11 accept only size 1. Size code 3 is always rejected. A rejected access is answered with an error and issues no downstream request.
- R9: Any offset other than 0x064 and 0x068 to 0x06F is answered with an error, read data zero, and no downstream request.
- R10: From acceptance of a window access until its response, `req_ready` is 0. The response appears the cycle after `dn_rsp_valid` is seen, without error, with read data zero for writes.
- R11: Each accepted valid window access produces `dn_valid` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor access request |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_size | input | 2 | Size code (0:1 B, 1:2 B, 2:4 B) |
| req_wdata | input | 32 | Write value, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read value, right-justified |
| dn_valid | output | 1 | One-cycle downstream request strobe |
| dn_space | output | 1 | 0 = configuration space, 1 = I/O space |
| dn_write | output | 1 | Downstream direction |
| dn_size | output | 2 | Downstream size code |
| dn_addr | output | 32 | Downstream address |
| dn_wdata | output | 32 | Downstream write value |
| dn_rsp_valid | input | 1 | Downstream completion strobe |
| dn_rsp_rdata | input | 32 | Downstream read value |

## Verification
The assertions assume that `dn_rsp_valid` is raised only while a downstream request is outstanding, at most once per request. They also assume the processor holds `req_valid` for only a single cycle and presents a new access only after the previous response. The bench acts as both sides. It drives one access at a time and answers every downstream request exactly once, with a latency of zero to three cycles. It draws offsets mostly from the mapped word range and sometimes from the whole 4 KiB space.

// File: rtl/idx_cfg_io_bridge.sv
module idx_cfg_io_bridge #(
  parameter int OFS_W = 12,
  parameter int IO_AW = 16,
  parameter logic [OFS_W-1:0] IDX_OFS = 12'h064,
  parameter logic [OFS_W-1:0] CFG_OFS = 12'h068,
  parameter logic [OFS_W-1:0] IO_OFS  = 12'h06C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_addr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             dn_valid,
  output logic             dn_space,
  output logic             dn_write,
  output logic [1:0]       dn_size,
  output logic [31:0]      dn_addr,
  output logic [31:0]      dn_wdata,
  input  logic             dn_rsp_valid,
  input  logic [31:0]      dn_rsp_rdata
);

  localparam int PAD_W = 32 - IO_AW;

  function automatic logic [31:0] trim(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    trim = {24'd0, d[7:0]};
      2'd1:    trim = {16'd0, d[15:0]};
      default: trim = d;
    endcase
  endfunction

  function automatic logic [31:0] flip(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    flip = {24'd0, d[7:0]};
      2'd1:    flip = {16'd0, d[7:0], d[15:8]};
      default: flip = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  logic        busy;
  logic        sel_cfg;
  logic [31:0] idx_q;
  logic        fit_ok;

  wire [1:0] lo      = req_addr[1:0];
  wire       hit_idx = (req_addr == IDX_OFS);
  wire       hit_cfg = (req_addr[OFS_W-1:2] == CFG_OFS[OFS_W-1:2]);
  wire       hit_io  = (req_addr[OFS_W-1:2] == IO_OFS[OFS_W-1:2]);
  wire       idx_go  = hit_idx && (req_size == 2'd2);
  wire       win_go  = (hit_cfg || hit_io) && fit_ok;
  wire       accept  = req_valid && req_ready;

  wire [31:0] cfg_addr = idx_q | {30'd0, lo};
  wire [31:0] io_sum   = idx_q + {30'd0, lo};
  wire [31:0] io_addr  = {{PAD_W{1'b0}}, io_sum[IO_AW-1:0]};

  assign req_ready = !busy;

  always_comb begin
    case (req_size)
      2'd0:    fit_ok = 1'b1;
      2'd1:    fit_ok = !lo[0];
      2'd2:    fit_ok = (lo == 2'b00);
      default: fit_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sel_cfg   <= 1'b0;
      idx_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      dn_valid  <= 1'b0;
      dn_space  <= 1'b0;
      dn_write  <= 1'b0;
      dn_size   <= 2'd0;
      dn_addr   <= '0;
      dn_wdata  <= '0;
    end else begin
      dn_valid  <= 1'b0;
      rsp_valid <= 1'b0;
      if (accept) begin
        if (win_go) begin
          busy     <= 1'b1;
          dn_valid <= 1'b1;
          dn_space <= hit_io;
          dn_write <= req_write;
          dn_size  <= req_size;
          dn_addr  <= hit_io ? io_addr : cfg_addr;
          dn_wdata <= !req_write ? 32'd0 :
                      hit_io ? trim(req_size, req_wdata) : flip(req_size, req_wdata);
          sel_cfg  <= hit_cfg;
        end else begin
          rsp_valid <= 1'b1;
          rsp_err   <= !idx_go;
          rsp_rdata <= (idx_go && !req_write) ? idx_q : 32'd0;
          if (idx_go && req_write) idx_q <= {req_wdata[31:2], 2'b00};
        end
      end else if (busy && dn_rsp_valid) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b0;
        rsp_rdata <= dn_write ? 32'd0 :
                     sel_cfg ? flip(dn_size, dn_rsp_rdata) : trim(dn_size, dn_rsp_rdata);
      end
    end
  end

endmodule

// File: rtl/idx_cfg_io_bridge_chk.sv
module idx_cfg_io_bridge_chk #(
  parameter int IO_AW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        dn_valid,
  input logic        dn_space,
  input logic [1:0]  dn_size,
  input logic [31:0] dn_addr,
  input logic        dn_rsp_valid
);

  p_dn_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |=> !dn_valid);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !req_ready);

  p_rsp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(dn_rsp_valid)));

  p_dn_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_size != 2'd3));

  p_cfg_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_space && dn_size == 2'd2) |-> ((dn_addr & 32'd3) == 32'd0));

  p_io_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_space) |-> ((dn_addr >> IO_AW) == 32'd0));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !dn_valid);

endmodule

bind idx_cfg_io_bridge idx_cfg_io_bridge_chk #(.IO_AW(IO_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .dn_valid(dn_valid),
  .dn_space(dn_space), .dn_size(dn_size), .dn_addr(dn_addr),
  .dn_rsp_valid(dn_rsp_valid)
);

// File: tb/sim_idx_cfg_io_bridge.sv
module sim_idx_cfg_io_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic dn_valid, dn_space, dn_write;
  logic [1:0] dn_size;
  logic [31:0] dn_addr, dn_wdata;
  logic dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;

  int nchk = 0, nbad = 0, cycles = 0;
  logic [31:0] idx_m = '0;

  always #10 clk = ~clk;

  idx_cfg_io_bridge u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bfit(input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r = '0;
    for (int i = 0; i < (1 << sz); i++) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] bswap(input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r = '0;
    int n = 1 << sz;
    for (int i = 0; i < n; i++) r[8*i +: 8] = d[8*(n-1-i) +: 8];
    return r;
  endfunction

  task automatic run(input bit wr, input logic [11:0] off, input logic [1:0] sz,
                     input logic [31:0] wd, input logic [31:0] dnr, input int lat);
    bit win, cfg, isidx, aok, eerr, goes, got, wait_on, busy_bad;
    logic [1:0] lo;
    logic [31:0] erd, g_rd, c_addr, c_wd;
    logic g_err, c_sp, c_wr;
    logic [1:0] c_sz;
    int ndn, cyc, wcnt;
    string et;
    lo = off[1:0];
    win = (off >= 12'h068) && (off <= 12'h06F);
    cfg = off < 12'h06C;
    isidx = (off == 12'h064);
    aok = (sz == 2'd0) || (sz == 2'd1 && !lo[0]) || (sz == 2'd2 && lo == 2'b00);
    eerr = isidx ? (sz != 2'd2) : (win ? !aok : 1'b1);
    goes = win && aok;
    et = isidx ? "R3" : (win ? "R8" : "R9");
    erd = 32'd0;
    if (!eerr && !wr) erd = isidx ? idx_m : (cfg ? bswap(sz, bfit(sz, dnr)) : bfit(sz, dnr));
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = off; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    ndn = 0; cyc = 0; got = 0; wait_on = 0; wcnt = 0; busy_bad = 0;
    g_err = 0; g_rd = 0; c_addr = 0; c_wd = 0; c_sp = 0; c_wr = 0; c_sz = 0;
    while (!got && cyc < 50) begin
      if (dn_valid) begin
        ndn++; c_addr = dn_addr; c_wd = dn_wdata; c_sp = dn_space; c_wr = dn_write; c_sz = dn_size;
        wait_on = 1; wcnt = lat;
      end
      if (rsp_valid) begin got = 1; g_err = rsp_err; g_rd = rsp_rdata; end
      else if (goes && req_ready) busy_bad = 1;
      dn_rsp_valid = 1'b0;
      if (wait_on) begin
        if (wcnt == 0) begin dn_rsp_valid = 1'b1; dn_rsp_rdata = dnr; wait_on = 0; end
        else wcnt--;
      end
      if (!got) begin @(negedge clk); cyc++; end
    end
    dn_rsp_valid = 1'b0;
    chk("R10 response arrived", {31'd0, got}, 32'd1);
    chk(eerr ? et : "R2 no error", {31'd0, g_err}, {31'd0, eerr});
    chk(isidx ? "R2 read data" : (cfg ? "R5 read data" : "R7 read data"), g_rd, erd);
    chk(goes ? "R11 one request" : (isidx ? "R2 no request" : "R8/R9 no request"), ndn, goes ? 1 : 0);
    if (goes) begin
      chk("R10 ready low while busy", {31'd0, busy_bad}, 32'd0);
      chk(cfg ? "R4 space" : "R6 space", {31'd0, c_sp}, cfg ? 32'd0 : 32'd1);
      chk(cfg ? "R4 address" : "R6 address", c_addr,
          cfg ? (idx_m | {30'd0, lo}) : ((idx_m + {30'd0, lo}) & 32'h0000FFFF));
      chk("R4 direction and size", {29'd0, c_wr, c_sz}, {29'd0, wr, sz});
      if (wr) chk(cfg ? "R5 write data" : "R7 write data", c_wd,
                  cfg ? bswap(sz, bfit(sz, wd)) : bfit(sz, wd));
    end
    if (isidx && wr && !eerr) idx_m = {wd[31:2], 2'b00};
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 150000) begin
        nchk++; nbad++;
        $display("FAIL watchdog act=%0d exp<150000", cycles);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp idle", {31'd0, rsp_valid}, 32'd0);
    chk("R1 dn idle", {31'd0, dn_valid}, 32'd0);
    run(0, 12'h064, 2'd2, 0, 0, 0);                      // R1 index reads zero
    run(1, 12'h064, 2'd2, 32'hFFFF_FFFF, 0, 0);          // R2 low bits cleared
    run(0, 12'h064, 2'd2, 0, 0, 0);
    run(1, 12'h064, 2'd1, 32'h1234_5678, 0, 0);          // R3 rejected
    run(1, 12'h064, 2'd0, 32'h0000_0055, 0, 0);          // R3 rejected
    run(0, 12'h064, 2'd2, 0, 0, 0);                      // R3 index unchanged
    run(1, 12'h064, 2'd2, 32'h8000_1230, 0, 0);
    run(0, 12'h06B, 2'd0, 0, 32'hAABB_CCDD, 2);          // R4 OR of offset
    run(1, 12'h068, 2'd2, 32'h1122_3344, 0, 1);          // R5 reversal
    run(0, 12'h06A, 2'd1, 0, 32'h0000_BEEF, 0);          // R5 two-byte reversal
    run(1, 12'h064, 2'd2, 32'h1234_FFFC, 0, 0);
    run(0, 12'h06F, 2'd0, 0, 32'h0000_00A5, 3);          // R6 truncated add
    run(1, 12'h06E, 2'd1, 32'hFFFF_CAFE, 0, 0);          // R7 masked, unreversed
    run(0, 12'h06D, 2'd1, 0, 0, 0);                      // R8 odd offset two bytes
    run(0, 12'h06A, 2'd2, 0, 0, 0);                      // R8 offset 2 four bytes
    run(1, 12'h06C, 2'd3, 0, 0, 0);                      // R8 bad size code
    run(0, 12'h000, 2'd2, 0, 0, 0);                      // R9 unmapped
    run(1, 12'h066, 2'd0, 0, 0, 0);                      // R9 inside index word
    for (int k = 0; k < 400; k++) begin
      logic [11:0] o;
      if (($urandom % 4) != 3) o = 12'h064 + 12'($urandom % 12);
      else o = 12'($urandom % 4096);
      run($urandom % 2, o, 2'($urandom % 4), $urandom, $urandom, $urandom % 4);
    end
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule